// File: doc/BRIEF.md
# Wide-Operand Accelerator Register Wrapper

This block sits on a 32-bit memory-mapped slave port and lets a processor drive a compute unit whose operands and result are each 128 bits wide. Software stores two operands one 32-bit word at a time. Storing the most significant word of the second operand starts an operation. Software then polls a status word until the operation is done and fetches the 128-bit result as four 32-bit reads.

The write side and the read side decode the 5-bit byte address separately. A byte offset can therefore name an operand word when written and a result or status word when read. The compute unit in this project is a stand-in with a fixed latency of 26 clocks that returns the bitwise XOR of the two operands. The wrapper can therefore be exercised on its own, and a real engine with the same latency contract can replace the stand-in later.

Top module: `wide_op_accel`

## Requirements
- R1: A synchronous active-high reset clears both operand registers, the result register, the busy and done flags, and the read data output to zero.
- R2: A write takes effect only when the write strobe is high. The word index is byte address bits 4:2, and bits 1:0 are ignored. Indices 0 to 3 load operand A and indices 4 to 7 load operand B. Word k of an operand holds bits 32k+31 down to 32k.
- R3: A write to byte offset 0x1C launches an operation on both operands, including the word being written. From the next clock, busy reads 1 and done reads 0.
- R4: Busy falls and done rises on the 26th clock edge after the launch edge. A status read captured on that edge still shows busy, and a read captured one edge later shows done.
- R5: The result is operand A XOR operand B. Reads at byte offsets 0x00, 0x04, 0x08 and 0x0C return result bits 31:0, 63:32, 95:64 and 127:96.
- R6: A read at byte offset 0x10 returns the status word: bit 0 is done, bit 1 is busy, and all other bits are zero.
- R7: The result register changes only when an operation completes. Reads made during a later operation return the previous result.
- R8: Read data appears on the clock after the read strobe and holds its value until the next read.
- R9: Reads at byte offsets 0x14, 0x18 and 0x1C return zero.
- R10: A launch while busy restarts the operation with the new operands, and the full latency is counted again from that launch.
- R11: With the write strobe low, address and data on the bus leave the operands, busy and done unchanged.
- R12: Done stays set until the next launch. Operand writes after a launch do not change the result of the operation already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_write | input | 1 | Write strobe |
| bus_read | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |

## Verification
The hardest case to reach is a second launch that arrives while an operation is still counting. If the counter were not restarted, the first operation would finish ten clocks too early, and nothing at the ports would show the difference unless status is sampled in that window. The stimulus therefore launches, relaunches ten clocks later, and reads status once at a point where an unrestarted counter would already show done. It also reads status on the exact edges where completion should and should not yet be visible. A write of an operand word in the middle of an operation then confirms that the in-flight result was taken from the operands held at launch.

// File: rtl/woa_pkg.sv
package woa_pkg;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_BUSY_BIT = 1;

  typedef struct packed {
    logic busy;
    logic done;
  } woa_status_t;
endpackage

// File: rtl/woa_wr_decode.sv
module woa_wr_decode #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 128
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  we,
  input  logic [$clog2(2*(OP_W/DATA_W))-1:0]    widx,
  input  logic [DATA_W-1:0]                     wdata,
  output logic [OP_W-1:0]                       opa_q,
  output logic [OP_W-1:0]                       opb_q,
  output logic [OP_W-1:0]                       opb_next,
  output logic                                  launch
);
  localparam int WORDS  = OP_W / DATA_W;
  localparam int WIDX_W = $clog2(2 * WORDS);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit_a, hit_b;
    assign hit_a = we && (widx == WIDX_W'(g));
    assign hit_b = we && (widx == WIDX_W'(WORDS + g));

    always_ff @(posedge clk) begin
      if (rst) begin
        opa_q[g*DATA_W +: DATA_W] <= '0;
        opb_q[g*DATA_W +: DATA_W] <= '0;
      end else begin
        if (hit_a) opa_q[g*DATA_W +: DATA_W] <= wdata;
        if (hit_b) opb_q[g*DATA_W +: DATA_W] <= wdata;
      end
    end

    assign opb_next[g*DATA_W +: DATA_W] = hit_b ? wdata : opb_q[g*DATA_W +: DATA_W];
  end

  assign launch = we && (widx == WIDX_W'(2 * WORDS - 1));

  // R11
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(opa_q) && $stable(opb_q));

  // R2
  opa_load_chk: assert property (@(posedge clk) disable iff (rst)
    we && (widx == '0) |=> opa_q[DATA_W-1:0] == $past(wdata));
endmodule

// File: rtl/woa_compute.sv
module woa_compute #(
  parameter int OP_W    = 128,
  parameter int LATENCY = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic [OP_W-1:0] a_in,
  input  logic [OP_W-1:0] b_in,
  output logic [OP_W-1:0] result_q,
  output logic            busy,
  output logic            done
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [CNT_W-1:0] cnt;
  logic [OP_W-1:0]  hold_a, hold_b;
  logic             finish;

  assign finish = busy && (cnt == '0) && !launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a <= '0;
      hold_b <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (launch) begin
      hold_a <= a_in;
      hold_b <= b_in;
      cnt    <= CNT_W'(LATENCY - 1);
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         result_q <= '0;
    else if (finish) result_q <= hold_a ^ hold_b;
  end

  // R3
  launch_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy && !done);

  // R4
  count_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && (cnt != '0) |=> busy);

  // R4
  done_after_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy) && ($past(cnt) == '0));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && (cnt == '0)) |=> $stable(result_q));

  // R12
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done && !launch |=> done);
endmodule

// File: rtl/woa_rd_mux.sv
module woa_rd_mux #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 128
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  re,
  input  logic [$clog2(2*(OP_W/DATA_W))-1:0]    widx,
  input  logic [OP_W-1:0]                       result,
  input  woa_pkg::woa_status_t                  status,
  output logic [DATA_W-1:0]                     rdata
);
  localparam int WORDS  = OP_W / DATA_W;
  localparam int WIDX_W = $clog2(2 * WORDS);

  logic [DATA_W-1:0] word_sel [WORDS];
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] next_data;

  for (genvar g = 0; g < WORDS; g++) begin : g_res
    assign word_sel[g] = result[g*DATA_W +: DATA_W];
  end

  always_comb begin
    stat_word = '0;
    stat_word[woa_pkg::STAT_DONE_BIT] = status.done;
    stat_word[woa_pkg::STAT_BUSY_BIT] = status.busy;
  end

  always_comb begin
    next_data = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (widx == WIDX_W'(k)) next_data = word_sel[k];
    end
    if (widx == WIDX_W'(WORDS)) next_data = stat_word;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= next_data;
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    re && (widx > WIDX_W'(WORDS)) |=> rdata == '0);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));

  // R6
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    re && (widx == WIDX_W'(WORDS)) |=> rdata[DATA_W-1:2] == '0);
endmodule

// File: rtl/wide_op_accel.sv
module wide_op_accel #(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 128,
  parameter int ADDR_W  = 5,
  parameter int LATENCY = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_write,
  input  logic              bus_read,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int WORDS  = OP_W / DATA_W;
  localparam int WIDX_W = $clog2(2 * WORDS);
  localparam int LSB    = $clog2(DATA_W / 8);

  logic [WIDX_W-1:0]    widx;
  logic [OP_W-1:0]      opa_q, opb_q, opb_next, result_q;
  logic                 launch, busy, done;
  woa_pkg::woa_status_t status;

  assign widx = WIDX_W'(bus_addr >> LSB);
  assign status.busy = busy;
  assign status.done = done;

  woa_wr_decode #(.DATA_W(DATA_W), .OP_W(OP_W)) u_wr (
    .clk(clk), .rst(rst), .we(bus_write), .widx(widx), .wdata(bus_wdata),
    .opa_q(opa_q), .opb_q(opb_q), .opb_next(opb_next), .launch(launch)
  );

  woa_compute #(.OP_W(OP_W), .LATENCY(LATENCY)) u_cu (
    .clk(clk), .rst(rst), .launch(launch), .a_in(opa_q), .b_in(opb_next),
    .result_q(result_q), .busy(busy), .done(done)
  );

  woa_rd_mux #(.DATA_W(DATA_W), .OP_W(OP_W)) u_rd (
    .clk(clk), .rst(rst), .re(bus_read), .widx(widx), .result(result_q),
    .status(status), .rdata(bus_rdata)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0) && !busy && !done && (result_q == '0));

  // R12
  hidden_b_unused_chk: assert property (@(posedge clk) disable iff (rst)
    !launch && busy |=> busy || done);

  initial begin
    param_map_chk: assert (ADDR_W == LSB + WIDX_W);
  end
endmodule

// File: tb/wide_op_accel_test.sv
module wide_op_accel_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 26;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_write, bus_read;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  logic [127:0] ea, eb, eres;

  wide_op_accel uut (
    .clk(clk), .rst(rst), .bus_write(bus_write), .bus_read(bus_read),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result on the negedge after its capture edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_read === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    int k;
    k = a[4:2];
    if (k < 4) ea[k*32 +: 32] = d;
    else       eb[(k-4)*32 +: 32] = d;
    bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_write = 1'b0;
  endtask

  task automatic nowr(logic [4:0] a, logic [31:0] d);
    bus_write = 1'b0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_read = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_read = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_result(string tag);
    for (int k = 0; k < 4; k++) rd(5'(k*4), eres[k*32 +: 32], tag);
  endtask

  task automatic finish_run();
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] pend;
    rst = 1'b1; bus_write = 1'b0; bus_read = 1'b0; bus_addr = '0; bus_wdata = '0;
    ea = '0; eb = '0; eres = '0;
    idle(3);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;
    rd(5'h10, 32'h0, "R1 status after reset");
    rd(5'h00, 32'h0, "R1 result after reset");

    // launch with only the top word written: cleared operands show through
    wr(5'h1C, 32'hA5A5_0001);
    eres = ea ^ eb;
    idle(LAT - 1);
    rd(5'h10, 32'h2, "R4 busy on completion edge");
    rd(5'h10, 32'h1, "R4 R6 done one edge later");
    rd(5'h0C, 32'hA5A5_0001, "R5 top word");
    rd(5'h00, 32'h0, "R1 operand A cleared");

    // full operand load, one write with low address bits set
    wr(5'h00, 32'h1234_5678);
    wr(5'h05, 32'h9ABC_DEF0);
    wr(5'h08, 32'h0F0F_0F0F);
    wr(5'h0C, 32'hFFFF_0000);
    wr(5'h10, 32'h1111_1111);
    wr(5'h14, 32'h2222_2222);
    wr(5'h18, 32'h3333_3333);
    wr(5'h1C, 32'h4444_4444);
    pend = ea ^ eb;
    rd(5'h10, 32'h2, "R3 busy after launch");
    rd(5'h0C, eres[127:96], "R7 previous result during op");
    idle(LAT + 2);
    eres = pend;
    read_result("R2 R5 result words");
    rd(5'h10, 32'h1, "R6 done status");

    // read data holds with no read strobe
    rd(5'h04, eres[63:32], "R8 read word 1");
    idle(3);
    check("R8 rdata holds", bus_rdata, eres[63:32]);

    // unmapped reads
    rd(5'h14, 32'h0, "R9 offset 0x14");
    rd(5'h18, 32'h0, "R9 offset 0x18");
    rd(5'h1C, 32'h0, "R9 offset 0x1C");

    // strobe low: no launch, no operand change
    nowr(5'h1C, 32'hDEAD_BEEF);
    idle(2);
    rd(5'h10, 32'h1, "R11 no launch without strobe");
    nowr(5'h00, 32'hCAFE_F00D);
    wr(5'h1C, eb[127:96]);
    idle(LAT + 2);
    rd(5'h00, ea[31:0] ^ eb[31:0], "R11 operand A unchanged");

    // operand write during an operation does not affect it
    wr(5'h1C, 32'h5555_AAAA);
    pend = ea ^ eb;
    wr(5'h00, 32'h0000_FFFF);
    idle(LAT + 2);
    eres = pend;
    rd(5'h00, eres[31:0], "R12 in-flight operands kept");
    rd(5'h10, 32'h1, "R12 done stays set");
    wr(5'h1C, 32'h0101_0101);
    rd(5'h10, 32'h2, "R12 done cleared by launch");

    // relaunch while busy
    idle(LAT + 2);
    wr(5'h1C, 32'h7777_0000);
    idle(9);
    wr(5'h1C, 32'h8888_0000);
    pend = ea ^ eb;
    idle(16);
    rd(5'h10, 32'h2, "R10 still busy after restart");
    idle(8);
    rd(5'h10, 32'h2, "R10 busy on restarted completion edge");
    rd(5'h10, 32'h1, "R10 done after restarted latency");
    eres = pend;
    read_result("R10 result from second launch");

    finish_run();
  end
endmodule